// File: doc/BRIEF.md
# Conditional Relative Branch Resolver

This block resolves the conditional relative branches of an 8-bit processor that uses a 16-bit program counter. On each request it takes the branch opcode byte, the signed 8-bit displacement that follows it, the four condition flags (negative, overflow, zero, carry) and the address where the opcode sits. One clock later it returns four results. The first says whether the byte is a branch at all. The second says whether the branch is taken. The third is the next program counter. The fourth is the number of machine cycles the branch costs.

The condition is decoded from the opcode. The top two bits pick one flag, and bit 5 gives the value that flag must hold for the branch to be taken. Every branch is two bytes long, so the fall-through address is the opcode address plus two. A taken branch adds the sign-extended displacement to that fall-through address. The cycle cost depends on the outcome. Page crossing is judged from the high byte of the fall-through address, not the high byte of the opcode address.

The sequencer uses this block to pick its next fetch address and to plan the cycles a branch occupies. It handles no memory access and no other instruction.

Top module: `branch_resolver`

## Requirements
- R1: The branch condition is selected by opcode bits 7:6: 00 picks N, 01 picks V, 10 picks C and 11 picks Z. Bit 5 is the flag value that takes the branch. This gives the eight branch opcodes 0x10 (N=0), 0x30 (N=1), 0x50 (V=0), 0x70 (V=1), 0x90 (C=0), 0xB0 (C=1), 0xD0 (Z=0) and 0xF0 (Z=1).
- R2: An opcode whose low five bits are not 5'b10000 is reported with `is_branch`=0, `taken`=0, `cycles`=0 and `next_pc` equal to the opcode address plus two.
- R3: When a branch is not taken, `next_pc` is the opcode address plus 2, modulo 2^16.
- R4: When a branch is taken, `next_pc` is (opcode address + 2 + sign-extended displacement) modulo 2^16. A displacement of 0x06 lands 8 bytes past the opcode, and 0xFA lands 4 bytes before it.
- R5: `cycles` is 2 for an untaken branch, 3 for a taken branch that stays on the same page, and 4 for a taken branch that crosses a page.
- R6: A page crossing means the high byte of the target differs from the high byte of the fall-through address. A taken branch with displacement 0 therefore always costs 3 cycles, even when the opcode sits at the end of a page.
- R7: Results appear on the clock edge after a request and `res_valid` is high for exactly that cycle. Without a request, all results hold their last values.
- R8: While reset is held and directly after it, `res_valid`, `is_branch` and `taken` are 0, `cycles` is 0 and `next_pc` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A branch is presented this cycle |
| opcode | input | 8 | Opcode byte under evaluation |
| disp | input | 8 | Signed two's-complement displacement |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| op_addr | input | 16 | Address of the opcode byte |
| res_valid | output | 1 | Results below are fresh this cycle |
| is_branch | output | 1 | Opcode is one of the eight branches |
| taken | output | 1 | Branch condition was met |
| next_pc | output | 16 | Next program counter |
| cycles | output | 3 | Machine cycles consumed by the branch |

## Verification
The assertions check several properties on every cycle. They check the one-cycle latency and hold behaviour of the result register. They check that a non-branch leaves `taken` low and `cycles` at zero. They check that an untaken branch falls through to the opcode address plus two in exactly 2 cycles, and that every branch costs between 2 and 4 cycles. Other behaviours can only be shown by the bench's directed scenarios, which compare against values computed independently: the flag-to-opcode mapping, the exact taken target for forward and backward displacements, the crossing judged against the fall-through page, the zero-displacement case at a page end, and 16-bit wrap-around.

// File: rtl/brn_pkg.sv
package brn_pkg;

  typedef enum logic [1:0] {
    SEL_NEG   = 2'b00,
    SEL_OVF   = 2'b01,
    SEL_CARRY = 2'b10,
    SEL_ZERO  = 2'b11
  } flag_sel_e;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } cc_flags_t;

  localparam logic [4:0] BR_LOW_PATTERN = 5'b10000;

  localparam int unsigned CYC_W         = 3;
  localparam int unsigned CYC_NONE      = 0;
  localparam int unsigned CYC_UNTAKEN   = 2;
  localparam int unsigned CYC_NEAR      = 3;
  localparam int unsigned CYC_FAR       = 4;

endpackage

// File: rtl/brn_cond_decode.sv
module brn_cond_decode
  import brn_pkg::*;
#(
  parameter int unsigned OP_W = 8
) (
  input  logic [OP_W-1:0] opcode_i,
  input  cc_flags_t       flags_i,
  output logic            is_branch_o,
  output logic            cond_met_o,
  output flag_sel_e       sel_o
);

  localparam int unsigned SEL_HI  = OP_W - 1;
  localparam int unsigned SEL_LO  = OP_W - 2;
  localparam int unsigned WANT_BIT = OP_W - 3;

  // Low field must match the branch pattern exactly
  function automatic logic low_matches(input logic [OP_W-1:0] op);
    return op[4:0] == BR_LOW_PATTERN;
  endfunction

  // Pick one flag out of four by selector
  function automatic logic pick_flag(input flag_sel_e s, input cc_flags_t f);
    logic r;
    case (s)
      SEL_NEG:   r = f.n;
      SEL_OVF:   r = f.v;
      SEL_CARRY: r = f.c;
      default:   r = f.z;
    endcase
    return r;
  endfunction

  logic picked;
  logic wanted;

  always_comb begin
    sel_o       = flag_sel_e'(opcode_i[SEL_HI:SEL_LO]);
    wanted      = opcode_i[WANT_BIT];
    picked      = pick_flag(sel_o, flags_i);
    is_branch_o = low_matches(opcode_i);
    cond_met_o  = is_branch_o && (picked == wanted);
  end

  // R2: a non-branch opcode never reports a met condition
  always_comb begin
    if (!is_branch_o) a_r2_no_cond_off_branch: assert (!cond_met_o);
  end

endmodule

// File: rtl/brn_target_calc.sv
module brn_target_calc #(
  parameter int unsigned PC_W     = 16,
  parameter int unsigned DISP_W   = 8,
  parameter int unsigned PAGE_W   = 8,
  parameter int unsigned INSN_LEN = 2
) (
  input  logic [PC_W-1:0]   op_addr_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [PC_W-1:0]   fall_pc_o,
  output logic [PC_W-1:0]   target_pc_o,
  output logic              page_cross_o
);

  localparam int unsigned PAGE_HI_W = PC_W - PAGE_W;
  localparam int unsigned EXT_W     = PC_W - DISP_W;

  function automatic logic [PC_W-1:0] sext_disp(input logic [DISP_W-1:0] d);
    return {{EXT_W{d[DISP_W-1]}}, d};
  endfunction

  function automatic logic [PAGE_HI_W-1:0] page_of(input logic [PC_W-1:0] a);
    return a[PC_W-1:PAGE_W];
  endfunction

  function automatic logic [PC_W-1:0] step_past(input logic [PC_W-1:0] a);
    return a + PC_W'(INSN_LEN);
  endfunction

  always_comb begin
    fall_pc_o    = step_past(op_addr_i);
    target_pc_o  = fall_pc_o + sext_disp(disp_i);
    page_cross_o = page_of(target_pc_o) != page_of(fall_pc_o);
  end

  // R6: a zero displacement can never leave the fall-through page
  always_comb begin
    if (disp_i == '0) a_r6_zero_disp_same_page: assert (!page_cross_o);
  end

endmodule

// File: rtl/brn_cycle_count.sv
module brn_cycle_count
  import brn_pkg::*;
(
  input  logic             is_branch_i,
  input  logic             taken_i,
  input  logic             page_cross_i,
  output logic [CYC_W-1:0] cycles_o
);

  always_comb begin
    if (!is_branch_i)      cycles_o = CYC_W'(CYC_NONE);
    else if (!taken_i)     cycles_o = CYC_W'(CYC_UNTAKEN);
    else if (page_cross_i) cycles_o = CYC_W'(CYC_FAR);
    else                   cycles_o = CYC_W'(CYC_NEAR);
  end

endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import brn_pkg::*;
#(
  parameter int unsigned PC_W   = 16,
  parameter int unsigned OP_W   = 8,
  parameter int unsigned DISP_W = 8,
  parameter int unsigned PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [OP_W-1:0]   opcode,
  input  logic [DISP_W-1:0] disp,
  input  logic              flag_n,
  input  logic              flag_v,
  input  logic              flag_z,
  input  logic              flag_c,
  input  logic [PC_W-1:0]   op_addr,
  output logic              res_valid,
  output logic              is_branch,
  output logic              taken,
  output logic [PC_W-1:0]   next_pc,
  output logic [CYC_W-1:0]  cycles
);

  cc_flags_t        flags_w;
  flag_sel_e        sel_w;
  logic             is_branch_w;
  logic             cond_met_w;
  logic [PC_W-1:0]  fall_pc_w;
  logic [PC_W-1:0]  target_pc_w;
  logic             page_cross_w;
  logic [CYC_W-1:0] cycles_w;
  logic [PC_W-1:0]  chosen_pc_w;

  assign flags_w = '{n: flag_n, v: flag_v, z: flag_z, c: flag_c};

  brn_cond_decode #(.OP_W(OP_W)) u_decode (
    .opcode_i    (opcode),
    .flags_i     (flags_w),
    .is_branch_o (is_branch_w),
    .cond_met_o  (cond_met_w),
    .sel_o       (sel_w)
  );

  brn_target_calc #(
    .PC_W     (PC_W),
    .DISP_W   (DISP_W),
    .PAGE_W   (PAGE_W),
    .INSN_LEN (2)
  ) u_target (
    .op_addr_i    (op_addr),
    .disp_i       (disp),
    .fall_pc_o    (fall_pc_w),
    .target_pc_o  (target_pc_w),
    .page_cross_o (page_cross_w)
  );

  brn_cycle_count u_cycles (
    .is_branch_i  (is_branch_w),
    .taken_i      (cond_met_w),
    .page_cross_i (page_cross_w),
    .cycles_o     (cycles_w)
  );

  assign chosen_pc_w = cond_met_w ? target_pc_w : fall_pc_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      is_branch <= 1'b0;
      taken     <= 1'b0;
      next_pc   <= '0;
      cycles    <= '0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        is_branch <= is_branch_w;
        taken     <= cond_met_w;
        next_pc   <= chosen_pc_w;
        cycles    <= cycles_w;
      end
    end
  end

  // R7: result strobe follows the request by one cycle
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);
  a_r7_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(next_pc) && $stable(taken) && $stable(cycles)
                    && $stable(is_branch)));

  // R2: a non-branch is inert
  a_r2_nonbranch_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !is_branch) |-> (!taken && cycles == '0));

  // R5: cycle cost bounds and untaken cost
  a_r5_cycle_range: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && is_branch) |-> (cycles >= CYC_W'(CYC_UNTAKEN)
                                  && cycles <= CYC_W'(CYC_FAR)));
  a_r5_untaken_two: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && is_branch && !taken) |-> (cycles == CYC_W'(CYC_UNTAKEN)));

  // R3: an untaken request falls through to opcode address + 2
  a_r3_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !cond_met_w) |=>
      (next_pc == PC_W'($past(op_addr) + PC_W'(2))));

endmodule

// File: tb/branch_resolver_tb.sv
module branch_resolver_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  opcode = '0;
  logic [7:0]  disp = '0;
  logic        flag_n = 1'b0, flag_v = 1'b0, flag_z = 1'b0, flag_c = 1'b0;
  logic [15:0] op_addr = '0;
  logic        res_valid, is_branch, taken;
  logic [15:0] next_pc;
  logic [2:0]  cycles;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  branch_resolver u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .opcode(opcode),
    .disp(disp), .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z),
    .flag_c(flag_c), .op_addr(op_addr), .res_valid(res_valid),
    .is_branch(is_branch), .taken(taken), .next_pc(next_pc), .cycles(cycles)
  );

  task automatic check(input string tag, input string what,
                       input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", tag, what, got, exp);
    end
  endtask

  // Independent reference: flag chosen by the opcode value itself
  function automatic bit ref_taken(input logic [7:0] op, input logic [3:0] nvzc);
    case (op)
      8'h10: return !nvzc[3];
      8'h30: return  nvzc[3];
      8'h50: return !nvzc[2];
      8'h70: return  nvzc[2];
      8'h90: return !nvzc[0];
      8'hB0: return  nvzc[0];
      8'hD0: return !nvzc[1];
      8'hF0: return  nvzc[1];
      default: return 0;
    endcase
  endfunction

  function automatic bit ref_is_branch(input logic [7:0] op);
    return op inside {8'h10, 8'h30, 8'h50, 8'h70, 8'h90, 8'hB0, 8'hD0, 8'hF0};
  endfunction

  // Present one request, then sample at the following falling edge
  task automatic issue(input logic [7:0] op, input logic [7:0] d,
                       input logic [3:0] nvzc, input logic [15:0] a);
    @(negedge clk);
    opcode = op; disp = d; op_addr = a;
    {flag_n, flag_v, flag_z, flag_c} = nvzc;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_and_check(input string tag, input logic [7:0] op,
                               input logic [7:0] d, input logic [3:0] nvzc,
                               input logic [15:0] a);
    int fall, tgt, exp_pc, exp_cyc;
    bit tk, br;
    issue(op, d, nvzc, a);
    br   = ref_is_branch(op);
    tk   = ref_taken(op, nvzc);
    fall = (int'(a) + 2) % 65536;
    tgt  = (fall + $signed(d) + 65536) % 65536;
    exp_pc = tk ? tgt : fall;
    if (!br) exp_cyc = 0;
    else if (!tk) exp_cyc = 2;
    else if ((tgt / 256) != (fall / 256)) exp_cyc = 4;
    else exp_cyc = 3;
    check(tag, "res_valid", int'(res_valid), 1);
    check(tag, "is_branch", int'(is_branch), int'(br));
    check(tag, "taken",     int'(taken),     int'(tk));
    check(tag, "next_pc",   int'(next_pc),   exp_pc);
    check(tag, "cycles",    int'(cycles),    exp_cyc);
  endtask

  task automatic t_reset();
    check("R8", "res_valid", int'(res_valid), 0);
    check("R8", "is_branch", int'(is_branch), 0);
    check("R8", "taken",     int'(taken),     0);
    check("R8", "next_pc",   int'(next_pc),   0);
    check("R8", "cycles",    int'(cycles),    0);
  endtask

  task automatic t_all_conditions();
    for (int i = 0; i < 8; i++) begin
      logic [7:0] op;
      op = 8'(i * 32 + 16);
      for (int f = 0; f < 16; f += 5) begin
        run_and_check("R1", op, 8'h10, 4'(f), 16'h4000);
      end
      run_and_check("R1", op, 8'h10, 4'h0, 16'h4000);
      run_and_check("R1", op, 8'h10, 4'hF, 16'h4000);
    end
  endtask

  task automatic t_directions();
    run_and_check("R4", 8'hF0, 8'h06, 4'b0010, 16'h2000);
    check("R4", "fwd lands +8", int'(next_pc), 16'h2008);
    run_and_check("R4", 8'hF0, 8'hFA, 4'b0010, 16'h2010);
    check("R4", "bwd lands -4", int'(next_pc), 16'h200C);
    run_and_check("R3", 8'hD0, 8'h40, 4'b0010, 16'h3456);
    check("R3", "untaken pc", int'(next_pc), 16'h3458);
  endtask

  task automatic t_page_cross();
    run_and_check("R5", 8'h90, 8'h01, 4'b0000, 16'h10FD);
    check("R5", "far fwd cost", int'(cycles), 4);
    run_and_check("R5", 8'h90, 8'h80, 4'b0000, 16'h1050);
    check("R5", "far bwd cost", int'(cycles), 4);
    run_and_check("R5", 8'h90, 8'h7F, 4'b0000, 16'h1000);
    check("R5", "near cost", int'(cycles), 3);
    run_and_check("R6", 8'h90, 8'h00, 4'b0000, 16'h10FE);
    check("R6", "zero disp at page end", int'(cycles), 3);
    run_and_check("R6", 8'h90, 8'hFF, 4'b0000, 16'h10FE);
    check("R6", "back to opcode page", int'(cycles), 4);
  endtask

  task automatic t_non_branch();
    run_and_check("R2", 8'hEA, 8'h20, 4'hF, 16'h1234);
    run_and_check("R2", 8'h00, 8'h20, 4'h0, 16'h1234);
    run_and_check("R2", 8'h18, 8'h20, 4'h0, 16'h1234);
    run_and_check("R2", 8'h11, 8'h20, 4'h0, 16'h1234);
    check("R2", "non-branch pc", int'(next_pc), 16'h1236);
  endtask

  task automatic t_wrap();
    run_and_check("R3", 8'h10, 8'h00, 4'b1000, 16'hFFFE);
    check("R3", "wrap untaken", int'(next_pc), 16'h0000);
    run_and_check("R4", 8'h10, 8'h80, 4'b0000, 16'h0002);
    check("R4", "wrap backward", int'(next_pc), 16'hFF84);
    run_and_check("R4", 8'h10, 8'h7F, 4'b0000, 16'hFFF0);
    check("R4", "wrap forward", int'(next_pc), 16'h0071);
  endtask

  task automatic t_hold();
    logic [15:0] pc0;
    run_and_check("R7", 8'h70, 8'h05, 4'b0100, 16'h0800);
    pc0 = next_pc;
    @(negedge clk);
    opcode = 8'hF0; disp = 8'h30; op_addr = 16'h9000;
    {flag_n, flag_v, flag_z, flag_c} = 4'b0010;
    repeat (3) @(negedge clk);
    check("R7", "idle valid", int'(res_valid), 0);
    check("R7", "held pc",    int'(next_pc),   int'(pc0));
    check("R7", "held taken", int'(taken),     1);
    check("R7", "held cycles", int'(cycles),   3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", "after reset", int'(res_valid), 0);
    t_all_conditions();
    t_directions();
    t_page_cross();
    t_non_branch();
    t_wrap();
    t_hold();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000 - 100);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got hung expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule